// File: doc/BRIEF.md
# ALU with Stored Compare Result

This block is the arithmetic and compare core of a small 16-bit processor. A 3-bit select picks one of eight operations on two 16-bit operands: add, subtract, multiply, unsigned divide, unsigned remainder, and three bitwise operations. The result comes out combinationally in the same cycle. A divide or remainder with a zero divisor returns a fixed value and raises a fault output that the sequencer can trap on.

A compare strobe makes the block store the wrapped difference A minus B in a hidden 16-bit register. The sequencer picks what it places on the B operand: a second register or an immediate. No general register is written by a compare. The stored difference is read as a signed number. Six branch-taken outputs, one for each conditional jump, are decoded from its sign and zero state. The sequencer picks the bit that matches the branch it is executing. Register access and instruction fetch are outside the block.

Top module: `alu_cmp`

## Requirements
- R1: `op_i` encodes 0 add, 1 sub, 2 mul, 3 div, 4 mod, 5 and, 6 or, 7 xor. Add and sub return the sum and difference modulo 2^16 in the same cycle.
- R2: mul returns the low 16 bits of the unsigned product.
- R3: div with a nonzero `b_i` returns the unsigned quotient of `a_i` by `b_i`.
- R4: mod with a nonzero `b_i` returns the unsigned remainder of `a_i` by `b_i`.
- R5: and, or and xor return the bitwise combination of `a_i` and `b_i`.
- R6: With `b_i` zero, div returns 0xFFFF and mod returns `a_i`, and `fault_o` is high. `fault_o` is low for every other operation and for any nonzero divisor.
- R7: After reset the stored difference is zero, so `taken_o` reads 6'b101001.
- R8: A clock edge with `cmp_i` high stores `a_i - b_i` modulo 2^16. Edges with `cmp_i` low leave the stored value, and therefore `taken_o`, unchanged, whatever the operand and select inputs do.
- R9: `taken_o` bits are 0: equal (diff == 0), 1: not equal, 2: less (diff < 0), 3: less or equal, 4: greater (diff > 0), 5: greater or equal. They follow the stored value from the clock edge that stores it.
- R10: The stored difference is compared as a signed 16-bit value after wrap, so 0x0001 minus 0x8001 (0x8000) counts as less, and 0x8000 minus 0x0001 (0x7FFF) counts as greater.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation select |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand (register or immediate) |
| cmp_i | input | 1 | Store a_i - b_i as the compare result |
| result_o | output | 16 | Operation result |
| fault_o | output | 1 | Divide or remainder by zero |
| taken_o | output | 6 | Branch-taken flags decoded from the stored difference |

## Verification
The hardest state to reach is a stored difference whose signed reading disagrees with a plain unsigned or unwrapped comparison of the operands. To reach it, the bench compares operand pairs that straddle 0x8000, so that the wrapped subtraction flips sign. It then checks that less and greater follow the wrapped sign. The stored value is also held across several cycles while the operands and the select change with the strobe low. This shows that only the strobe edge moves the branch flags.

// File: rtl/alu_cmp_pkg.sv
package alu_cmp_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_DIV = 3'd3,
    OP_MOD = 3'd4,
    OP_AND = 3'd5,
    OP_OR  = 3'd6,
    OP_XOR = 3'd7
  } alu_op_e;

  localparam int unsigned COND_EQ = 0;
  localparam int unsigned COND_NE = 1;
  localparam int unsigned COND_LT = 2;
  localparam int unsigned COND_LE = 3;
  localparam int unsigned COND_GT = 4;
  localparam int unsigned COND_GE = 5;
  localparam int unsigned NUM_COND = 6;
endpackage

// File: rtl/alu_divider.sv
// Combinational restoring divider, one stage per quotient bit.
// A zero divisor naturally yields all-ones quotient and remainder == dividend.
module alu_divider #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] part [W+1];

  assign part[0] = '0;

  for (genvar s = 0; s < W; s++) begin : g_stage
    logic [W:0]   shifted;
    logic [W-1:0] diff;
    logic         fits;
    assign shifted = {part[s], num_i[W-1-s]};
    assign diff    = shifted[W-1:0] - den_i;
    assign fits    = shifted[W] | (shifted[W-1:0] >= den_i);
    assign part[s+1]       = fits ? diff : shifted[W-1:0];
    assign quo_o[W-1-s]    = fits;
  end

  assign rem_o = part[W];
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_cmp_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] result_o,
  output logic         fault_o
);
  alu_op_e      op;
  logic [W-1:0] quo, rem, prod;
  logic         den_zero;

  assign op       = alu_op_e'(op_i);
  assign den_zero = (b_i == '0);
  assign prod     = a_i * b_i;

  alu_divider #(.W(W)) u_div (
    .num_i (a_i),
    .den_i (b_i),
    .quo_o (quo),
    .rem_o (rem)
  );

  always_comb begin
    unique case (op)
      OP_ADD:  result_o = a_i + b_i;
      OP_SUB:  result_o = a_i - b_i;
      OP_MUL:  result_o = prod;
      OP_DIV:  result_o = den_zero ? '1 : quo;
      OP_MOD:  result_o = den_zero ? a_i : rem;
      OP_AND:  result_o = a_i & b_i;
      OP_OR:   result_o = a_i | b_i;
      OP_XOR:  result_o = a_i ^ b_i;
      default: result_o = '0;
    endcase
  end

  assign fault_o = den_zero & ((op == OP_DIV) | (op == OP_MOD));
endmodule

// File: rtl/alu_cond.sv
// Stored signed difference and branch condition decode.
module alu_cond
  import alu_cmp_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmp_i,
  input  logic [W-1:0]        a_i,
  input  logic [W-1:0]        b_i,
  output logic [NUM_COND-1:0] taken_o
);
  logic [W-1:0] diff_q;
  logic         is_zero, is_neg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    diff_q <= '0;
    else if (cmp_i) diff_q <= a_i - b_i;
  end

  assign is_zero = (diff_q == '0);
  assign is_neg  = diff_q[W-1];

  always_comb begin
    taken_o          = '0;
    taken_o[COND_EQ] = is_zero;
    taken_o[COND_NE] = ~is_zero;
    taken_o[COND_LT] = is_neg;
    taken_o[COND_LE] = is_neg | is_zero;
    taken_o[COND_GT] = ~is_neg & ~is_zero;
    taken_o[COND_GE] = ~is_neg;
  end
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp
  import alu_cmp_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          op_i,
  input  logic [W-1:0]        a_i,
  input  logic [W-1:0]        b_i,
  input  logic                cmp_i,
  output logic [W-1:0]        result_o,
  output logic                fault_o,
  output logic [NUM_COND-1:0] taken_o
);
  alu_datapath #(.W(W)) u_dp (
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o),
    .fault_o  (fault_o)
  );

  alu_cond #(.W(W)) u_cond (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmp_i   (cmp_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .taken_o (taken_o)
  );
endmodule

// File: rtl/alu_cmp_chk.sv
module alu_cmp_chk
  import alu_cmp_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [2:0]          op_i,
  input logic [W-1:0]        a_i,
  input logic [W-1:0]        b_i,
  input logic                cmp_i,
  input logic [W-1:0]        result_o,
  input logic                fault_o,
  input logic [NUM_COND-1:0] taken_o
);
  p_div_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_DIV && b_i == '0) |-> (result_o == '1 && fault_o));

  p_mod_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MOD && b_i == '0) |-> (result_o == a_i && fault_o));

  p_no_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_i != '0) |-> !fault_o);

  p_div_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_DIV && b_i != '0) |-> (result_o <= a_i));

  p_mod_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MOD && b_i != '0) |-> (result_o < b_i));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_i |=> $stable(taken_o));

  p_eq_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_i |=> (taken_o[COND_EQ] == ($past(a_i) == $past(b_i))));

  p_one_order_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({taken_o[COND_EQ], taken_o[COND_LT], taken_o[COND_GT]}) == 1);

  p_pairs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o[COND_NE] != taken_o[COND_EQ]) && (taken_o[COND_GE] != taken_o[COND_LT])
    && (taken_o[COND_LE] != taken_o[COND_GT]));
endmodule

bind alu_cmp alu_cmp_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .cmp_i    (cmp_i),
  .result_o (result_o),
  .fault_o  (fault_o),
  .taken_o  (taken_o)
);

// File: tb/tb_alu_cmp.sv
module tb_alu_cmp;
  localparam int W = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    op_i = '0;
  logic [W-1:0]  a_i = '0;
  logic [W-1:0]  b_i = '0;
  logic          cmp_i = 1'b0;
  logic [W-1:0]  result_o;
  logic          fault_o;
  logic [5:0]    taken_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  alu_cmp #(.W(W)) dut (.*);

  function automatic logic [5:0] exp_taken(input logic [W-1:0] d);
    logic signed [W-1:0] s;
    s = d;
    return {s >= 0, s > 0, s <= 0, s < 0, s != 0, s == 0};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; cmp_i = 1'b0;
    #1;
  endtask

  task automatic do_cmp(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk_i);
    a_i = a; b_i = b; cmp_i = 1'b1;
    @(negedge clk_i);
    cmp_i = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    #1;
    chk("R7 reset taken", 32'(taken_o), 32'(6'b101001));
  endtask

  task automatic t_add_sub;
    logic [W-1:0] a [3] = '{16'h1234, 16'hFFFF, 16'h0000};
    logic [W-1:0] b [3] = '{16'h0F0F, 16'h0002, 16'h0001};
    for (int i = 0; i < 3; i++) begin
      apply(3'd0, a[i], b[i]);
      chk("R1 add", 32'(result_o), 32'(W'(a[i] + b[i])));
      apply(3'd1, a[i], b[i]);
      chk("R1 sub", 32'(result_o), 32'(W'(a[i] - b[i])));
    end
  endtask

  task automatic t_mul;
    apply(3'd2, 16'h0123, 16'h0045);
    chk("R2 mul", 32'(result_o), 32'(W'(32'h0123 * 32'h0045)));
    apply(3'd2, 16'hFFFF, 16'hFFFF);
    chk("R2 mul wrap", 32'(result_o), 32'h0001);
    apply(3'd2, 16'h8000, 16'h0002);
    chk("R2 mul overflow", 32'(result_o), 32'h0000);
  endtask

  task automatic t_div_mod;
    logic [W-1:0] a [4] = '{16'd1000, 16'hFFFF, 16'd7, 16'h8001};
    logic [W-1:0] b [4] = '{16'd7, 16'd1, 16'd9, 16'h8000};
    for (int i = 0; i < 4; i++) begin
      apply(3'd3, a[i], b[i]);
      chk("R3 div", 32'(result_o), 32'(a[i] / b[i]));
      chk("R6 no fault div", 32'(fault_o), 32'd0);
      apply(3'd4, a[i], b[i]);
      chk("R4 mod", 32'(result_o), 32'(a[i] % b[i]));
    end
  endtask

  task automatic t_logic;
    apply(3'd5, 16'hF0F0, 16'h3C3C);
    chk("R5 and", 32'(result_o), 32'h3030);
    apply(3'd6, 16'hF0F0, 16'h3C3C);
    chk("R5 or", 32'(result_o), 32'hFCFC);
    apply(3'd7, 16'hF0F0, 16'h3C3C);
    chk("R5 xor", 32'(result_o), 32'hCCCC);
  endtask

  task automatic t_div_zero;
    apply(3'd3, 16'h1234, 16'h0000);
    chk("R6 div0 result", 32'(result_o), 32'hFFFF);
    chk("R6 div0 fault", 32'(fault_o), 32'd1);
    apply(3'd4, 16'hBEEF, 16'h0000);
    chk("R6 mod0 result", 32'(result_o), 32'hBEEF);
    chk("R6 mod0 fault", 32'(fault_o), 32'd1);
    apply(3'd0, 16'h1234, 16'h0000);
    chk("R6 add b0 no fault", 32'(fault_o), 32'd0);
  endtask

  task automatic t_cmp_basic;
    logic [W-1:0] a [3] = '{16'd5, 16'd3, 16'd9};
    logic [W-1:0] b [3] = '{16'd5, 16'd8, 16'd2};
    for (int i = 0; i < 3; i++) begin
      do_cmp(a[i], b[i]);
      chk("R9 taken after cmp", 32'(taken_o), 32'(exp_taken(W'(a[i] - b[i]))));
    end
  endtask

  task automatic t_cmp_hold;
    do_cmp(16'd3, 16'd8);
    for (int i = 0; i < 4; i++) begin
      apply(3'(i), 16'(i * 77), 16'(i * 3));
      @(negedge clk_i);
      #1;
      chk("R8 hold without cmp", 32'(taken_o), 32'(exp_taken(16'hFFFB)));
    end
  endtask

  task automatic t_cmp_signed;
    do_cmp(16'h0001, 16'h8001);
    chk("R10 wrap to negative", 32'(taken_o), 32'(6'b001110));
    do_cmp(16'h8000, 16'h0001);
    chk("R10 wrap to positive", 32'(taken_o), 32'(6'b110010));
    do_cmp(16'h8000, 16'h8000);
    chk("R8 equal high values", 32'(taken_o), 32'(6'b101001));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #7 rst_ni = 1'b1;
    t_reset();
    t_add_sub();
    t_mul();
    t_div_mod();
    t_logic();
    t_div_zero();
    t_cmp_basic();
    t_cmp_hold();
    t_cmp_signed();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule